// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block decides whether a small serial flash carries out a command that changes stored data. An SPI mode-0 front end hands it one decoded command per chip-select rise. Each command comes with its opcode, the sector-select address bit, the number of clock pulses counted while chip select was low, and the status data byte that a status write carries. The block keeps the status register: the busy flag, the write-enable latch, two block-protect bits and the status-lock bit. It also tracks deep power-down. It samples the write-protect pin at the moment a command is decided.

For status writes, page programs, sector erases and bulk erases, the block raises exactly one of two pulses, accept or reject, one cycle after the command arrives. An accepted command also raises a start strobe with an operation code toward the array and sets busy. The array model answers with a done pulse. That pulse clears busy and the write-enable latch. A timer that starts at power-on reset blocks all modifying commands until it expires.

Top module: `flash_wp_ctrl`

## Requirements
- R1: During and right after synchronous reset, the status byte is 0x00, deep power-down is off, and accept, reject and start are all low.
- R2: For the first PUW_CYCLES clock cycles after reset is released, every status write, page program, sector erase and bulk erase is rejected.
- R3: A modifying command whose pulse count is not a multiple of eight is rejected.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. A modifying command issued while the latch is clear is rejected.
- R5: An accepted command pulses accept and start for one cycle, one cycle after cmd_valid. In that same cycle busy reads 1. array_op gives the operation: 0 for a status write (0x01), 1 for a page program (0x02), 2 for a sector erase (0xD8), 3 for a bulk erase (0xC7).
- R6: A done pulse that arrives while busy is set clears busy and the write-enable latch on the next cycle. A done pulse while idle has no effect.
- R7: A page program or sector erase is rejected when the block-protect field is nonzero, whichever sector the address MSB selects. It is not blocked when the field is zero.
- R8: A bulk erase is rejected unless both block-protect bits are 0.
- R9: A status write is rejected when the status-lock bit is 1 and wp_n is low. An accepted status write loads the block-protect bits from data bits 3:2 and the status-lock bit from data bit 7.
- R10: The status byte shows busy at bit 0, the write-enable latch at bit 1, the block-protect field at bits 3:2 and the status-lock bit at bit 7. Bits 6:4 read 0.
- R11: Opcode 0xB9 enters deep power-down. While in that state, every command except 0xAB is ignored: no accept or reject pulse and no status change. Opcode 0xAB leaves the state.
- R12: While busy is set, every command is ignored. This includes a command in the same cycle as the done pulse, which is judged against the busy state it sees.
- R13: Accept and reject never rise together, and each rises only in the cycle after a cmd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cmd_valid | input | 1 | One-cycle pulse: a decoded command is present |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | ADDR_W | Command address; the MSB selects the sector |
| cmd_bits | input | CNT_W | Clock pulses counted while chip select was low |
| cmd_wdata | input | 8 | Data byte carried by a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| array_done | input | 1 | Completion pulse from the array timer model |
| cmd_accept | output | 1 | Modifying command accepted |
| cmd_reject | output | 1 | Modifying command refused |
| array_start | output | 1 | Start strobe toward the array |
| array_op | output | 2 | Operation code that goes with array_start |
| status | output | 8 | Status register byte |
| deep_pd | output | 1 | Deep power-down state |

## Verification
Two events can coincide: the done pulse that ends a busy period, and a new command that arrives in the same cycle. The bench provokes this by driving a write-enable command together with array_done while busy is set. The bench expects the command to be judged against the busy state, so it is dropped. The completion still clears the latch, which leaves both busy and the write-enable latch at 0. Around that case, a sweep covers every combination of protect field, status-lock bit, write-protect pin, latch state, pulse count and sector for all four modifying commands, and each outcome is compared with a model built from the requirements.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    typedef enum logic [7:0] {
        OP_WRSR = 8'h01,
        OP_PP   = 8'h02,
        OP_WRDI = 8'h04,
        OP_RDSR = 8'h05,
        OP_WREN = 8'h06,
        OP_RES  = 8'hAB,
        OP_DP   = 8'hB9,
        OP_BE   = 8'hC7,
        OP_SE   = 8'hD8
    } opcode_e;

    typedef enum logic [1:0] {
        ARR_SR    = 2'd0,
        ARR_PROG  = 2'd1,
        ARR_SECT  = 2'd2,
        ARR_CHIP  = 2'd3
    } arr_op_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] prot;
        logic       wen;
        logic       busy;
    } sreg_t;

    typedef struct packed {
        logic    accept;
        logic    reject;
        logic    set_wen;
        logic    clr_wen;
        logic    load_sr;
        logic    enter_dp;
        logic    exit_dp;
        arr_op_e op;
    } verdict_t;

    // Byte view of the status register
    function automatic logic [7:0] sreg_byte(sreg_t s);
        return {s.lock, 3'b000, s.prot, s.wen, s.busy};
    endfunction

    // Any nonzero protect field covers both sectors
    function automatic logic sector_locked(logic [1:0] prot, logic sector);
        logic [1:0] mask;
        mask = (prot == 2'b00) ? 2'b00 : 2'b11;
        return mask[sector];
    endfunction

endpackage

// File: rtl/flash_wp_puw.sv
module flash_wp_puw #(
    parameter int unsigned CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    output logic ready
);
    localparam int unsigned W = $clog2(CYCLES + 2);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt != W'(CYCLES)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = (cnt == W'(CYCLES));
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
    import flash_wp_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             valid,
    input  logic [7:0]       op,
    input  logic             sector,
    input  logic [CNT_W-1:0] bits,
    input  logic             wp_n,
    input  sreg_t            sr,
    input  logic             dpd,
    input  logic             puw_ready,
    output verdict_t         dec
);
    logic whole;
    logic base_ok;
    logic ok;

    assign whole   = ((bits & CNT_W'(7)) == '0);
    assign base_ok = whole && sr.wen && puw_ready;

    always_comb begin
        dec = '0;
        ok  = 1'b0;
        if (valid && !sr.busy) begin
            if (dpd) begin
                dec.exit_dp = (op == OP_RES);
            end else begin
                case (op)
                    OP_WREN: dec.set_wen  = 1'b1;
                    OP_WRDI: dec.clr_wen  = 1'b1;
                    OP_DP:   dec.enter_dp = 1'b1;
                    OP_WRSR: begin
                        dec.op      = ARR_SR;
                        ok          = base_ok && !(sr.lock && !wp_n);
                        dec.accept  = ok;
                        dec.reject  = !ok;
                        dec.load_sr = ok;
                    end
                    OP_PP, OP_SE: begin
                        dec.op     = (op == OP_PP) ? ARR_PROG : ARR_SECT;
                        ok         = base_ok && !sector_locked(sr.prot, sector);
                        dec.accept = ok;
                        dec.reject = !ok;
                    end
                    OP_BE: begin
                        dec.op     = ARR_CHIP;
                        ok         = base_ok && (sr.prot == 2'b00);
                        dec.accept = ok;
                        dec.reject = !ok;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_wp_status.sv
module flash_wp_status
    import flash_wp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  verdict_t   dec,
    input  logic       new_lock,
    input  logic [1:0] new_prot,
    input  logic       done,
    output sreg_t      sr,
    output logic       dpd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            dpd <= 1'b0;
        end else begin
            if (done && sr.busy) begin
                sr.busy <= 1'b0;
                sr.wen  <= 1'b0;
            end
            if (dec.accept)   sr.busy <= 1'b1;
            if (dec.load_sr) begin
                sr.prot <= new_prot;
                sr.lock <= new_lock;
            end
            if (dec.set_wen)  sr.wen <= 1'b1;
            if (dec.clr_wen)  sr.wen <= 1'b0;
            if (dec.enter_dp) dpd    <= 1'b1;
            if (dec.exit_dp)  dpd    <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned PUW_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_bits,
    input  logic [7:0]        cmd_wdata,
    input  logic              wp_n,
    input  logic              array_done,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic              array_start,
    output logic [1:0]        array_op,
    output logic [7:0]        status,
    output logic              deep_pd
);
    localparam int unsigned SECT_BIT = ADDR_W - 1;

    logic     puw_ready;
    sreg_t    sr;
    logic     dpd;
    verdict_t dec;
    arr_op_e  op_q;
    logic     unused_ins;

    assign unused_ins = ^{cmd_addr[SECT_BIT-1:0], cmd_wdata[6:4], cmd_wdata[1:0]};

    flash_wp_puw #(.CYCLES(PUW_CYCLES)) i_puw (
        .clk   (clk),
        .rst   (rst),
        .ready (puw_ready)
    );

    flash_wp_gate #(.CNT_W(CNT_W)) i_gate (
        .valid     (cmd_valid),
        .op        (cmd_op),
        .sector    (cmd_addr[SECT_BIT]),
        .bits      (cmd_bits),
        .wp_n      (wp_n),
        .sr        (sr),
        .dpd       (dpd),
        .puw_ready (puw_ready),
        .dec       (dec)
    );

    flash_wp_status i_status (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .new_lock (cmd_wdata[7]),
        .new_prot (cmd_wdata[3:2]),
        .done     (array_done),
        .sr       (sr),
        .dpd      (dpd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_accept  <= 1'b0;
            cmd_reject  <= 1'b0;
            array_start <= 1'b0;
            op_q        <= ARR_SR;
        end else begin
            cmd_accept  <= dec.accept;
            cmd_reject  <= dec.reject;
            array_start <= dec.accept;
            if (dec.accept) op_q <= dec.op;
        end
    end

    assign array_op = op_q;
    assign status   = sreg_byte(sr);
    assign deep_pd  = dpd;
endmodule

// File: rtl/flash_wp_chk.sv
module flash_wp_chk #(
    parameter int unsigned PUW_CYCLES = 256
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       wp_n,
    input logic       array_done,
    input logic       cmd_accept,
    input logic       cmd_reject,
    input logic       array_start,
    input logic [7:0] status,
    input logic       deep_pd
);
    logic [31:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst < PUW_CYCLES) since_rst <= since_rst + 1;
    end

    p_puw_block_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && since_rst < PUW_CYCLES) |=> !cmd_accept);

    p_wen_needed_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !status[1]) |=> !cmd_accept);

    p_accept_busy_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |-> (status[0] && array_start));

    p_done_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (status[0] && array_done) |=> (!status[0] && !status[1]));

    p_hw_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (!wp_n && status[7]) |=> $stable(status[7:2]));

    p_zero_field_r10: assert property (@(posedge clk) disable iff (rst)
        status[6:4] == 3'b000);

    p_dpd_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (deep_pd && cmd_valid) |=> (!cmd_accept && !cmd_reject));

    p_busy_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (status[0] && cmd_valid) |=> (!cmd_accept && !cmd_reject));

    p_one_verdict_r13: assert property (@(posedge clk) disable iff (rst)
        $countones({cmd_accept, cmd_reject}) <= 1);

    p_verdict_cause_r13: assert property (@(posedge clk) disable iff (rst)
        (cmd_accept || cmd_reject) |-> $past(cmd_valid));
endmodule

bind flash_wp_ctrl flash_wp_chk #(.PUW_CYCLES(PUW_CYCLES)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .wp_n        (wp_n),
    .array_done  (array_done),
    .cmd_accept  (cmd_accept),
    .cmd_reject  (cmd_reject),
    .array_start (array_start),
    .status      (status),
    .deep_pd     (deep_pd)
);

// File: tb/test_flash_wp_ctrl.sv
module test_flash_wp_ctrl;
    localparam int PUW = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [7:0]  cmd_op;
    logic [15:0] cmd_addr;
    logic [15:0] cmd_bits;
    logic [7:0]  cmd_wdata;
    logic        wp_n;
    logic        array_done;
    logic        cmd_accept, cmd_reject, array_start, deep_pd;
    logic [1:0]  array_op;
    logic [7:0]  status;

    int checks = 0;
    int errors = 0;

    logic       m_wen, m_busy, m_dpd, m_lock, m_puw;
    logic [1:0] m_prot;

    always #4 clk = ~clk;

    flash_wp_ctrl #(.ADDR_W(16), .CNT_W(16), .PUW_CYCLES(PUW)) i_flash_wp_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_bits(cmd_bits), .cmd_wdata(cmd_wdata),
        .wp_n(wp_n), .array_done(array_done), .cmd_accept(cmd_accept),
        .cmd_reject(cmd_reject), .array_start(array_start), .array_op(array_op),
        .status(status), .deep_pd(deep_pd)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_sr();
        return {m_lock, 3'b000, m_prot, m_wen, m_busy};
    endfunction

    task automatic issue(string tag, logic [7:0] op, logic sector, int bits,
                         logic [7:0] wd, logic with_done);
        logic       e_acc = 1'b0;
        logic       e_rej = 1'b0;
        logic [1:0] e_op  = 2'd0;
        logic       pre_busy = m_busy;
        logic       ok;
        if (!m_busy) begin
            if (m_dpd) begin
                if (op == 8'hAB) m_dpd = 1'b0;
            end else begin
                case (op)
                    8'h06: m_wen = 1'b1;
                    8'h04: m_wen = 1'b0;
                    8'hB9: m_dpd = 1'b1;
                    8'h01, 8'h02, 8'hD8, 8'hC7: begin
                        ok = (bits % 8 == 0) && m_wen && m_puw;
                        if (op == 8'h01) begin
                            e_op = 2'd0;
                            if (m_lock && !wp_n) ok = 1'b0;
                        end else begin
                            e_op = (op == 8'h02) ? 2'd1 : (op == 8'hD8) ? 2'd2 : 2'd3;
                            if (m_prot != 2'b00) ok = 1'b0;
                        end
                        e_acc = ok;
                        e_rej = !ok;
                        if (ok) begin
                            m_busy = 1'b1;
                            if (op == 8'h01) begin
                                m_prot = wd[3:2];
                                m_lock = wd[7];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
        if (with_done && pre_busy) begin
            m_busy = 1'b0;
            m_wen  = 1'b0;
        end
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_op     = op;
        cmd_addr   = {sector, 15'h0123};
        cmd_bits   = 16'(bits);
        cmd_wdata  = wd;
        array_done = with_done;
        @(negedge clk);
        cmd_valid  = 1'b0;
        array_done = 1'b0;
        check(tag, "accept", cmd_accept, e_acc);
        check(tag, "reject", cmd_reject, e_rej);
        check(tag, "start", array_start, e_acc);
        if (e_acc) check("R5", "array_op", array_op, e_op);
        check(tag, "status", status, model_sr());
        check(tag, "deep_pd", deep_pd, m_dpd);
    endtask

    task automatic pulse_done();
        if (m_busy) begin
            m_busy = 1'b0;
            m_wen  = 1'b0;
        end
        @(negedge clk);
        array_done = 1'b1;
        @(negedge clk);
        array_done = 1'b0;
        check("R6", "status after done", status, model_sr());
    endtask

    task automatic configure(logic [1:0] prot, logic lock);
        wp_n = 1'b1;
        issue("R4", 8'h06, 1'b0, 8, 8'h00, 1'b0);
        issue("R9", 8'h01, 1'b0, 16, {lock, 3'b000, prot, 2'b00}, 1'b0);
        pulse_done();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] ops [4] = '{8'h01, 8'h02, 8'hD8, 8'hC7};
        int         bitset [3] = '{15, 16, 24};
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 8'h00; cmd_addr = '0;
        cmd_bits = '0; cmd_wdata = '0; wp_n = 1'b1; array_done = 1'b0;
        m_wen = 0; m_busy = 0; m_dpd = 0; m_lock = 0; m_prot = 2'b00; m_puw = 0;
        repeat (3) @(negedge clk);
        // R1 and R10 reset view
        check("R1", "status", status, 8'h00);
        check("R1", "deep_pd", deep_pd, 1'b0);
        check("R1", "accept", cmd_accept, 1'b0);
        check("R1", "reject", cmd_reject, 1'b0);
        check("R10", "start", array_start, 1'b0);
        rst = 1'b0;

        // R2: power-up window blocks writes
        issue("R4", 8'h06, 1'b0, 8, 8'h00, 1'b0);
        issue("R2", 8'h02, 1'b0, 32, 8'h00, 1'b0);
        issue("R2", 8'h01, 1'b0, 16, 8'h0C, 1'b0);
        repeat (PUW + 5) @(negedge clk);
        m_puw = 1'b1;

        // R4: write-disable then refusal
        issue("R4", 8'h04, 1'b0, 8, 8'h00, 1'b0);
        issue("R4", 8'h02, 1'b0, 32, 8'h00, 1'b0);

        // Sweep of protect, lock, pin, latch, count and sector
        for (int p = 0; p < 4; p++)
            for (int l = 0; l < 2; l++)
                for (int o = 0; o < 4; o++)
                    for (int w = 0; w < 2; w++)
                        for (int pin = 0; pin < 2; pin++)
                            for (int b = 0; b < 3; b++)
                                for (int s = 0; s < 2; s++) begin
                                    string tg;
                                    configure(2'(p), 1'(l));
                                    if (w != 0) issue("R4", 8'h06, 1'b0, 8, 8'h00, 1'b0);
                                    else        issue("R4", 8'h04, 1'b0, 8, 8'h00, 1'b0);
                                    wp_n = 1'(pin);
                                    if (bitset[b] % 8 != 0) tg = "R3";
                                    else if (w == 0)        tg = "R4";
                                    else if (o == 0)        tg = "R9";
                                    else if (o == 3)        tg = "R8";
                                    else                    tg = "R7";
                                    issue(tg, ops[o], 1'(s), bitset[b],
                                          {~1'(l), 3'b000, ~2'(p), 2'b00}, 1'b0);
                                    if (m_busy) pulse_done();
                                end
        wp_n = 1'b1;

        // R3: pulse counts 1..40
        configure(2'b00, 1'b0);
        for (int b = 1; b <= 40; b++) begin
            issue("R4", 8'h06, 1'b0, 8, 8'h00, 1'b0);
            issue("R3", 8'h02, 1'(b % 2), b, 8'h00, 1'b0);
            if (m_busy) pulse_done();
        end

        // R11: deep power-down
        issue("R4", 8'h06, 1'b0, 8, 8'h00, 1'b0);
        issue("R11", 8'hB9, 1'b0, 8, 8'h00, 1'b0);
        issue("R11", 8'h04, 1'b0, 8, 8'h00, 1'b0);
        issue("R11", 8'h02, 1'b0, 32, 8'h00, 1'b0);
        issue("R11", 8'hC7, 1'b0, 8, 8'h00, 1'b0);
        issue("R11", 8'hAB, 1'b0, 8, 8'h00, 1'b0);
        issue("R11", 8'h02, 1'b1, 32, 8'h00, 1'b0);

        // R12: busy window and done in the same cycle as a command
        issue("R12", 8'h04, 1'b0, 8, 8'h00, 1'b0);
        issue("R12", 8'hB9, 1'b0, 8, 8'h00, 1'b0);
        issue("R12", 8'h05, 1'b0, 8, 8'h00, 1'b0);
        issue("R12", 8'hD8, 1'b0, 32, 8'h00, 1'b0);
        issue("R12", 8'h06, 1'b0, 8, 8'h00, 1'b1);
        pulse_done();
        issue("R12", 8'h06, 1'b0, 8, 8'h00, 1'b0);
        issue("R5", 8'hC7, 1'b0, 8, 8'h00, 1'b0);
        pulse_done();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule